// File: doc/BRIEF.md
# USB-SPI Response Packetizer

This block turns the result of a bridged SPI transfer into device-to-host packets of at most 64 bytes, streamed one byte per cycle with a last-byte marker. An external SPI engine fills a local read buffer through a simple write port and then posts a command. The block answers with one of two things. It sends a start packet that carries a status word and the first read bytes, followed by as many offset-tagged continue packets as the read length needs. Or it sends a short configuration report when the host asks for one.

A transmit-done pulse from the endpoint paces the stream. After a packet's last byte, nothing more leaves the block until that pulse arrives, and then the next packet is built. A restart command replays the stored response from offset zero using the current buffer contents and the stored status, so a host that lost a packet can recover without a second SPI transfer. Any failure produces a status-only packet with no payload.

Top module: `usb_spi_rsp_packetizer`

## Requirements
- R1: After reset no byte is offered (`tx_valid` low) and no packet appears until a command arrives.
- R2: Command op 0 sends an 8-byte configuration packet, little-endian: 0x01 0x00, max write count (MAX_WR), max read count (BUF_BYTES), then a feature word whose bit 0 is FULL_DUPLEX and whose other bits are zero.
- R3: Command op 1 (SPI finished) with `cmd_fail` low starts a response whose first packet is 0x05 0x00, status 0x0000 (low byte first), then min(60, length) bytes taken from buffer address 0 upward.
- R4: Each later packet is 0x06 0x00, a 16-bit little-endian index equal to the number of read bytes already sent, then min(60, length − index) bytes from buffer address index upward. The response ends once all bytes are sent.
- R5: Command op 1 with `cmd_fail` high gives status 0x8000 ORed with `cmd_code[14:0]`.
- R6: Any non-zero status (a failed op 1, or op 2, which takes `cmd_code` as its status) forces the read length to 0, so only a 4-byte start packet is sent.
- R7: Command op 3 (restart) resends the whole last response from index 0 with the stored status and length.
- R8: After a packet's last byte is accepted, `tx_valid` stays low until a `tx_done` pulse. The next packet starts only after that pulse.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R10: A command that arrives while a response still has packets to send abandons them. The packet already streaming completes, and then the new command is served.
- R11: A read length of exactly 60 gives a single 64-byte start packet. A length of 0 with success gives a single 4-byte start packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 config, 1 SPI finished, 2 error, 3 restart |
| cmd_len | input | $clog2(BUF_BYTES+1) | Read length for op 1 (at most BUF_BYTES) |
| cmd_fail | input | 1 | Op 1: SPI engine reported an error |
| cmd_code | input | 16 | Op 1: engine error code; op 2: status word |
| buf_we | input | 1 | Read-buffer write enable |
| buf_addr | input | $clog2(BUF_BYTES) | Read-buffer write address |
| buf_wdata | input | 8 | Read-buffer write data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Last byte of the packet |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_done | input | 1 | Endpoint finished sending the previous packet |

## Verification
The hardest case to reach is a new command landing in the window between a finished packet and its `tx_done` pulse, while more response packets are still owed. Only there does abandonment (R10) differ from ordinary sequencing. The bench holds back `tx_done` after the first packet of a 200-byte response, posts a configuration request, and only then releases the pulse. It then expects exactly one configuration packet and silence after it. Restart is reached the same way, after a full multi-packet response and after an error response, so the replay is compared against the buffer the bench itself wrote.

// File: rtl/usb_spi_rsp_packetizer.sv
module usb_spi_rsp_packetizer #(
  parameter int BUF_BYTES   = 298,
  parameter int MAX_WR      = 298,
  parameter int CHUNK       = 60,
  parameter bit FULL_DUPLEX = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [1:0]                     cmd_op,
  input  logic [$clog2(BUF_BYTES+1)-1:0] cmd_len,
  input  logic                           cmd_fail,
  input  logic [15:0]                    cmd_code,
  input  logic                           buf_we,
  input  logic [$clog2(BUF_BYTES)-1:0]   buf_addr,
  input  logic [7:0]                     buf_wdata,
  output logic                           tx_valid,
  output logic [7:0]                     tx_data,
  output logic                           tx_last,
  input  logic                           tx_ready,
  input  logic                           tx_done
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = $clog2(BUF_BYTES + 1);
  localparam logic [15:0] WR_MAX = 16'(MAX_WR);
  localparam logic [15:0] RD_MAX = 16'(BUF_BYTES);

  typedef enum logic [1:0] {M_IDLE, M_CFG, M_START, M_CONT} mode_t;

  logic [7:0]    mem [BUF_BYTES];
  mode_t         mode;
  logic [15:0]   status_q;
  logic [LW-1:0] len_q, idx_q;
  logic          busy, wait_done, pkt_cfg;
  logic [6:0]    bcnt, pkt_len;
  logic [7:0]    pkt_type;
  logic [15:0]   pkt_field;
  logic [LW-1:0] pkt_base;

  logic [LW-1:0] remain, pay, nxt_idx, rd_sum;
  logic          start;

  assign remain  = len_q - idx_q;
  assign pay     = (remain > LW'(CHUNK)) ? LW'(CHUNK) : remain;
  assign nxt_idx = idx_q + pay;
  assign start   = (mode != M_IDLE) && !busy && !wait_done && !cmd_valid;
  assign rd_sum  = pkt_base + LW'(bcnt) - LW'(4);

  always_ff @(posedge clk)
    if (buf_we) mem[buf_addr] <= buf_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      status_q  <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      busy      <= 1'b0;
      wait_done <= 1'b0;
      pkt_cfg   <= 1'b0;
      bcnt      <= '0;
      pkt_len   <= '0;
      pkt_type  <= '0;
      pkt_field <= '0;
      pkt_base  <= '0;
    end else begin
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: mode <= M_CFG;
          2'd1: begin
            status_q <= cmd_fail ? {1'b1, cmd_code[14:0]} : 16'h0000;
            len_q    <= cmd_fail ? '0 : cmd_len;
            idx_q    <= '0;
            mode     <= M_START;
          end
          2'd2: begin
            status_q <= cmd_code;
            len_q    <= '0;
            idx_q    <= '0;
            mode     <= M_START;
          end
          default: begin
            idx_q <= '0;
            mode  <= M_START;
          end
        endcase
      end else if (start) begin
        busy <= 1'b1;
        bcnt <= '0;
        if (mode == M_CFG) begin
          pkt_cfg   <= 1'b1;
          pkt_type  <= 8'h01;
          pkt_field <= WR_MAX;
          pkt_len   <= 7'd8;
          mode      <= M_IDLE;
        end else begin
          pkt_cfg   <= 1'b0;
          pkt_type  <= (mode == M_START) ? 8'h05 : 8'h06;
          pkt_field <= (mode == M_START) ? status_q : 16'(idx_q);
          pkt_len   <= 7'd4 + 7'(pay);
          pkt_base  <= idx_q;
          idx_q     <= nxt_idx;
          mode      <= (nxt_idx < len_q) ? M_CONT : M_IDLE;
        end
      end

      if (busy && tx_ready) begin
        bcnt <= bcnt + 7'd1;
        if (tx_last) begin
          busy      <= 1'b0;
          wait_done <= 1'b1;
        end
      end
      if (wait_done && tx_done) wait_done <= 1'b0;
    end
  end

  assign tx_valid = busy;
  assign tx_last  = busy && (bcnt == pkt_len - 7'd1);

  always_comb begin
    case (bcnt)
      7'd0: tx_data = pkt_type;
      7'd1: tx_data = 8'h00;
      7'd2: tx_data = pkt_field[7:0];
      7'd3: tx_data = pkt_field[15:8];
      default:
        if (pkt_cfg)
          case (bcnt)
            7'd4:    tx_data = RD_MAX[7:0];
            7'd5:    tx_data = RD_MAX[15:8];
            7'd6:    tx_data = {7'd0, FULL_DUPLEX};
            default: tx_data = 8'h00;
          endcase
        else
          tx_data = mem[rd_sum[AW-1:0]];
    endcase
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && !busy && !cmd_valid) |=> !tx_valid);

  p_cfg_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last && pkt_cfg) |-> (bcnt == 7'd7));

  p_pkt_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (pkt_len <= 7'd64) && (pkt_len >= 7'd4));

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len_q);

  p_fail_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_fail) |=> status_q[15]);

  p_err_nolen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |=> (len_q == '0) && (mode == M_START));

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: tb/usb_spi_rsp_packetizer_tb.sv
module usb_spi_rsp_packetizer_tb_top;
  localparam int BUF = 298;
  localparam int MAXW = 298;
  localparam int AW = $clog2(BUF);
  localparam int LW = $clog2(BUF + 1);
  localparam int NV = 7;
  // {fail, code, length}
  localparam logic [32:0] VECS [NV] = '{
    {1'b0, 16'h0000, 16'd100},
    {1'b0, 16'h0000, 16'd60},
    {1'b0, 16'h0000, 16'd0},
    {1'b0, 16'h0000, 16'd61},
    {1'b0, 16'h0000, 16'd298},
    {1'b1, 16'h1234, 16'd50},
    {1'b1, 16'hFFFF, 16'd120}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_fail = 0, buf_we = 0, tx_ready = 1, tx_done = 0;
  logic [1:0] cmd_op = 0;
  logic [LW-1:0] cmd_len = 0;
  logic [15:0] cmd_code = 0;
  logic [AW-1:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;

  int checks = 0, errors = 0;
  logic [7:0] shadow [BUF];
  logic [7:0] rx [64];
  int rxn;

  always #4 clk = ~clk;

  usb_spi_rsp_packetizer #(.BUF_BYTES(BUF), .MAX_WR(MAXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_fail(cmd_fail), .cmd_code(cmd_code),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_done(tx_done));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < BUF; i++) begin
      @(negedge clk);
      buf_we = 1; buf_addr = AW'(i); buf_wdata = 8'(i * 7 + seed * 13);
      shadow[i] = 8'(i * 7 + seed * 13);
    end
    @(negedge clk); buf_we = 0;
  endtask

  task automatic cmd(input logic [1:0] op, input int len, input bit fail,
                     input logic [15:0] code);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_len = LW'(len); cmd_fail = fail; cmd_code = code;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic get_pkt(input bit bp, input bit give_done);
    int t = 0;
    bit fin = 0, hold = 0, quiet = 1;
    logic [7:0] held = 0;
    rxn = 0;
    while (!fin && t < 3000) begin
      @(negedge clk);
      t++;
      if (hold) chk(tx_valid && tx_data == held, "R9", "held byte", int'(tx_data), int'(held));
      hold = 0;
      tx_ready = bp ? (t % 3 != 1) : 1'b1;
      if (tx_valid) begin
        if (tx_ready) begin
          if (rxn < 64) rx[rxn] = tx_data;
          rxn++;
          if (tx_last) fin = 1;
        end else begin
          hold = 1; held = tx_data;
        end
      end
    end
    if (!fin) chk(0, "WDOG", "packet timeout", rxn, 0);
    tx_ready = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (tx_valid) quiet = 0;
    end
    chk(quiet, "R8", "idle before done", int'(quiet), 1);
    if (give_done) pulse_done();
  endtask

  task automatic expect_rsp(input logic [15:0] st, input int len, input bit bp,
                            input string req);
    int idx = 0;
    bit first = 1;
    bit quiet = 1;
    do begin
      int pay, bad;
      logic [7:0] e;
      get_pkt(bp, 1);
      pay = (len - idx > 60) ? 60 : len - idx;
      chk(rxn == 4 + pay, first ? req : "R4", "packet size", rxn, 4 + pay);
      bad = -1;
      for (int k = 0; k < 4 + pay && k < rxn; k++) begin
        case (k)
          0: e = first ? 8'h05 : 8'h06;
          1: e = 8'h00;
          2: e = first ? st[7:0] : 8'(idx);
          3: e = first ? st[15:8] : 8'(idx >> 8);
          default: e = shadow[idx + k - 4];
        endcase
        if (bad < 0 && rx[k] != e) bad = k;
      end
      chk(bad < 0, first ? req : "R4", "packet bytes", bad, -1);
      idx += pay;
      first = 0;
    end while (idx < len);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (tx_valid) quiet = 0;
    end
    chk(quiet, req, "no extra packet", int'(quiet), 1);
  endtask

  task automatic check_cfg(input string req);
    logic [7:0] e [8];
    int bad = -1;
    e = '{8'h01, 8'h00, 8'(MAXW), 8'(MAXW >> 8), 8'(BUF), 8'(BUF >> 8), 8'h01, 8'h00};
    chk(rxn == 8, req, "config size", rxn, 8);
    for (int k = 0; k < 8; k++) if (bad < 0 && rx[k] != e[k]) bad = k;
    chk(bad < 0, req, "config bytes", bad, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL WDOG: run did not end, actual 1 expected 0");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit quiet = 1;
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R1", "valid in reset", int'(tx_valid), 0);
    rst_n = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tx_valid) quiet = 0;
    end
    chk(quiet, "R1", "idle after reset", int'(quiet), 1);

    cmd(2'd0, 0, 0, 0);
    get_pkt(0, 1);
    check_cfg("R2");

    for (int v = 0; v < NV; v++) begin
      logic fail;
      logic [15:0] code, st;
      int len;
      string req;
      fail = VECS[v][32];
      code = VECS[v][31:16];
      len  = int'(VECS[v][15:0]);
      fill(v + 1);
      cmd(2'd1, len, fail, code);
      st = fail ? (16'h8000 | {1'b0, code[14:0]}) : 16'h0000;
      req = fail ? "R5" : ((len == 60 || len == 0) ? "R11" : "R3");
      expect_rsp(st, fail ? 0 : len, v[0], req);
    end

    cmd(2'd2, 77, 0, 16'h0003);
    expect_rsp(16'h0003, 0, 0, "R6");
    cmd(2'd3, 0, 0, 0);
    expect_rsp(16'h0003, 0, 0, "R7");

    fill(11);
    cmd(2'd1, 100, 0, 0);
    expect_rsp(16'h0000, 100, 1, "R3");
    cmd(2'd3, 0, 0, 0);
    expect_rsp(16'h0000, 100, 0, "R7");

    fill(12);
    cmd(2'd1, 200, 0, 0);
    get_pkt(0, 0);
    chk(rxn == 64 && rx[0] == 8'h05, "R10", "first packet", rxn, 64);
    cmd(2'd0, 0, 0, 0);
    pulse_done();
    get_pkt(0, 1);
    check_cfg("R10");
    quiet = 1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tx_valid) quiet = 0;
    end
    chk(quiet, "R10", "abandoned packets", int'(quiet), 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule